// File: doc/BRIEF.md
# Serial Slave with Split Measurement and Register Commands

This block is a four-wire serial slave. It has an active-low select, a serial clock, data in and data out, and it frames fixed 32-bit transactions. Each transaction begins with a 16-bit command word. One of two sub-commands is chosen by whichever byte of that word is all zero. When the low byte is zero, the high byte is a measurement request. The block decodes it and hands it on as a one-cycle start strobe that carries an axis field and a power-down field. When the high byte is zero, the low byte addresses one 16-bit register in a two-page register file, with 64 entries per page. The second half of the frame then carries 16 bits of write data from the master, or 16 bits of read data back to it.

All serial inputs are resynchronized into the system clock. That clock must run at least four times faster than the serial clock. Logic elsewhere on the chip reads the register file through a local, combinational read port.

Top module: `spi_reg_slave`

## Requirements
- R1: While rst_ni is low, and right after it rises, each register holds its own 7-bit index {page, addr}, zero-extended to 16 bits. miso_o, meas_start_o and err_o are 0.
- R2: Bits are shifted most significant bit first. The master changes data on the falling edge of the serial clock and the slave samples on the rising edge. The first 16 bits after select falls are the command word.
- R3: A command whose high byte is 0 is a register access. Bit 7 is the direction (1 = write, 0 = read), bit 6 is the page and bits 5:0 are the address. A write frame of exactly 32 bits stores its last 16 bits into register {page, addr} once select rises.
- R4: A register write frame with fewer or more than 32 rising edges leaves every register unchanged.
- R5: On a read, the addressed register is captured at the 16th rising edge. Its bit 15 appears on miso_o after the next falling edge, and the following bits appear after the falling edges that come after it. The master reads them on rising edges 17 to 32.
- R6: miso_o is 0 whenever select is high.
- R7: A command with low byte 0 and bit 15 = 1 is a measurement request. It gives a single-cycle meas_start_o after the 16th bit, with meas_axis_o = bits 14:13 and meas_pd_o = bit 8. No register changes.
- R8: A command with both bytes nonzero, or with a nonzero high byte whose bit 15 is 0, gives a single-cycle err_o. It produces no meas_start_o and changes no register.
- R9: The two pages are separate storage. A write to one page never alters the same address in the other page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master, 0 when not selected |
| meas_start_o | output | 1 | One-cycle measurement start strobe |
| meas_axis_o | output | 2 | Axis field of the last measurement request |
| meas_pd_o | output | 1 | Power-down field of the last measurement request |
| err_o | output | 1 | One-cycle flag for a malformed command |
| loc_addr_i | input | 7 | Local read address {page, addr} |
| loc_rdata_o | output | 16 | Local read data |

## Verification
A bit counter that slips by one position shows up in three ways:
- the command is decoded from the wrong bits;
- a read returns data shifted by one place on the 17th rising edge;
- a correct-length write is dropped, or an over-length write is kept.

Each of these is visible within one frame of about 550 system cycles. A wrong classification of the command shows within a few cycles of the 16th edge, as a missing or spurious strobe or error pulse. A misrouted page or address bit only shows on a later read of the other location, so the bench reads back every register it wrote, through both the serial port and the local port.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int CMD_W  = 16;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;

  typedef enum logic [1:0] {K_NONE, K_MEAS, K_REG, K_BAD} cmd_kind_e;

  typedef struct packed {
    logic       sel;
    logic [1:0] axis;
    logic [3:0] rsv;
    logic       pd;
  } meas_cmd_t;

  typedef struct packed {
    logic       wr;
    logic       page;
    logic [5:0] addr;
  } reg_cmd_t;

  function automatic cmd_kind_e classify(input logic [CMD_W-1:0] c);
    if (c[15:8] == 8'h00) return K_REG;
    if (c[7:0] != 8'h00 || !c[15]) return K_BAD;
    return K_MEAS;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= async_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int PAGES  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W:0]     wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W:0]     rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [ADDR_W:0]     loc_addr_i,
  output logic [DATA_W-1:0]   loc_rdata_o
);
  localparam int DEPTH = PAGES << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i);
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o   = mem_q[rd_addr_i];
  assign loc_rdata_o = mem_q[loc_addr_i];

  assert_write_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));

  assert_other_page_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> $stable(mem_q[{~$past(wr_addr_i[ADDR_W]), $past(wr_addr_i[ADDR_W-1:0])}]));
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = spi_reg_pkg::DATA_W,
  parameter int ADDR_W = spi_reg_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_i,
  input  logic              sclk_s_i,
  input  logic              mosi_s_i,
  output logic [ADDR_W:0]   rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [ADDR_W:0]   wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o,
  output logic              meas_start_o,
  output logic [1:0]        meas_axis_o,
  output logic              meas_pd_o,
  output logic              err_o
);
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_CMD      = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER     = CNT_W'(FRAME_BITS + 1);

  logic              sclk_d_q, cs_d_q;
  logic              sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, tx_q, cmd_next;
  cmd_kind_e         kind_q, kind_next;
  reg_cmd_t          rcmd_q, rc;
  meas_cmd_t         mc;
  logic              miso_q, cmd_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      cs_d_q   <= 1'b1;
    end else begin
      sclk_d_q <= sclk_s_i;
      cs_d_q   <= cs_s_i;
    end
  end

  assign sclk_rise = sclk_s_i & ~sclk_d_q & ~cs_s_i;
  assign sclk_fall = ~sclk_s_i & sclk_d_q & ~cs_s_i;
  assign cs_fall   = ~cs_s_i & cs_d_q;
  assign cs_rise   = cs_s_i & ~cs_d_q;

  assign cmd_next  = {sh_q[DATA_W-2:0], mosi_s_i};
  assign kind_next = classify(cmd_next);
  assign mc        = cmd_next[15:8];
  assign rc        = cmd_next[7:0];
  assign cmd_done  = sclk_rise && (cnt_q == CNT_CMD_LAST);
  assign rd_addr_o = {rc.page, rc.addr};

  // frame shift, count and command latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      kind_q <= K_NONE;
      rcmd_q <= '0;
      miso_q <= 1'b0;
    end else if (cs_fall) begin
      cnt_q  <= '0;
      kind_q <= K_NONE;
      miso_q <= 1'b0;
    end else if (sclk_rise) begin
      sh_q <= cmd_next;
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      if (cmd_done) begin
        kind_q <= kind_next;
        rcmd_q <= rc;
        tx_q   <= rd_data_i;
      end
    end else if (sclk_fall && kind_q == K_REG && !rcmd_q.wr && cnt_q >= CNT_CMD) begin
      miso_q <= tx_q[DATA_W-1];
      tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  // strobes and write commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meas_start_o <= 1'b0;
      meas_axis_o  <= '0;
      meas_pd_o    <= 1'b0;
      err_o        <= 1'b0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
    end else begin
      meas_start_o <= cmd_done && kind_next == K_MEAS;
      err_o        <= cmd_done && kind_next == K_BAD;
      if (cmd_done && kind_next == K_MEAS) begin
        meas_axis_o <= mc.axis;
        meas_pd_o   <= mc.pd;
      end
      wr_en_o   <= cs_rise && cnt_q == CNT_FULL && kind_q == K_REG && rcmd_q.wr;
      wr_addr_o <= {rcmd_q.page, rcmd_q.addr};
      wr_data_o <= sh_q;
    end
  end

  assign miso_o = ~cs_s_i & miso_q;

  assert_cnt_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);

  assert_start_after_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_start_o |-> (cnt_q == CMD_BITS_CHK()));

  assert_start_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_start_o |=> !meas_start_o);

  assert_err_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!meas_start_o && kind_q == K_BAD));

  assert_write_only_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ($past(cnt_q) == CNT_FULL && cs_s_i));

  function automatic logic [CNT_W-1:0] CMD_BITS_CHK();
    return CNT_CMD;
  endfunction
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int DATA_W      = spi_reg_pkg::DATA_W,
  parameter int ADDR_W      = spi_reg_pkg::ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              meas_start_o,
  output logic [1:0]        meas_axis_o,
  output logic              meas_pd_o,
  output logic              err_o,
  input  logic [ADDR_W:0]   loc_addr_i,
  output logic [DATA_W-1:0] loc_rdata_o
);
  logic [2:0]        pins_s;
  logic              wr_en;
  logic [ADDR_W:0]   wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({cs_ni, sclk_i, mosi_i}),
    .sync_o  (pins_s)
  );

  spi_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_s_i       (pins_s[2]),
    .sclk_s_i     (pins_s[1]),
    .mosi_s_i     (pins_s[0]),
    .rd_addr_o    (rd_addr),
    .rd_data_i    (rd_data),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .miso_o       (miso_o),
    .meas_start_o (meas_start_o),
    .meas_axis_o  (meas_axis_o),
    .meas_pd_o    (meas_pd_o),
    .err_o        (err_o)
  );

  spi_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGES(2)) u_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .loc_addr_i  (loc_addr_i),
    .loc_rdata_o (loc_rdata_o)
  );
endmodule

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic        miso, start, pd, err;
  logic [1:0]  axis;
  logic [6:0]  loc_addr = '0;
  logic [15:0] loc_rdata;

  int          n_chk = 0, n_err = 0;
  int          start_cnt = 0, err_cnt = 0, cs_hi = 0;
  logic        prev_start = 1'b0, prev_err = 1'b0;
  logic [1:0]  got_axis;
  logic        got_pd;
  logic [15:0] model [128];
  bit          done = 0;

  always #2 clk = ~clk;

  spi_reg_slave u_spi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .meas_start_o(start), .meas_axis_o(axis), .meas_pd_o(pd),
    .err_o(err), .loc_addr_i(loc_addr), .loc_rdata_o(loc_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      if (start) begin
        start_cnt++; got_axis = axis; got_pd = pd;
        check(!prev_start, "R7 strobe width", 1, 0);
        check(!err, "R8 exclusive", 1, 0);
      end
      if (err) begin
        err_cnt++;
        check(!prev_err, "R8 flag width", 1, 0);
      end
      cs_hi = cs_n ? cs_hi + 1 : 0;
      if (cs_hi >= 4) check(miso == 1'b0, "R6 idle miso", int'(miso), 0);
      prev_start = start; prev_err = err;
    end
  end

  task automatic xfer(input logic [31:0] w, input int nbits, output logic [15:0] rd);
    rd = '0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      mosi = (b < 32) ? w[31-b] : 1'b0;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      if (b >= 16 && b < 32) rd[31-b] = miso;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [15:0] d, input int nbits);
    logic [15:0] rd;
    xfer({8'h00, 1'b1, a, d}, nbits, rd);
    if (nbits == 32) model[a] = d;
  endtask

  task automatic spi_read_chk(input logic [6:0] a, input string req);
    logic [15:0] rd;
    xfer({8'h00, 1'b0, a, 16'h0000}, 32, rd);
    check(rd == model[a], req, rd, model[a]);
  endtask

  task automatic loc_chk(input logic [6:0] a, input string req);
    loc_addr = a;
    @(negedge clk);
    check(loc_rdata == model[a], req, loc_rdata, model[a]);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 16'(i);
    repeat (5) @(negedge clk);
    // R1: reset defaults
    check(miso == 0 && start == 0 && err == 0, "R1 outputs", {miso, start, err}, 0);
    loc_chk(7'h00, "R1 reset"); loc_chk(7'h45, "R1 reset"); loc_chk(7'h7F, "R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    loc_chk(7'h2A, "R1 after release");

    // R3 / R9: writes to both pages at the same address
    spi_write(7'h05, 16'hA5A5, 32);
    loc_chk(7'h05, "R3 write p0");
    loc_chk(7'h45, "R9 other page kept");
    spi_write(7'h45, 16'h1234, 32);
    loc_chk(7'h45, "R3 write p1");
    loc_chk(7'h05, "R9 p0 kept");

    // R5 / R2: serial readback, MSB first
    spi_read_chk(7'h45, "R5 read p1");
    spi_read_chk(7'h05, "R5 read p0");
    spi_read_chk(7'h3F, "R5 read default");
    spi_write(7'h10, 16'h8001, 32);
    spi_read_chk(7'h10, "R2 bit order");

    // R4: short and long frames
    spi_write(7'h07, 16'hFFFF, 24);
    loc_chk(7'h07, "R4 short frame");
    spi_write(7'h08, 16'hBEEF, 33);
    loc_chk(7'h08, "R4 long frame");
    spi_write(7'h09, 16'hCAFE, 31);
    loc_chk(7'h09, "R4 31-bit frame");

    // R7: measurement requests
    begin
      logic [15:0] rd;
      int s0;
      s0 = start_cnt;
      xfer({16'hC100, 16'h5A5A}, 32, rd);
      check(start_cnt == s0 + 1, "R7 strobe count", start_cnt - s0, 1);
      check(got_axis == 2'd2 && got_pd == 1'b1, "R7 fields", {got_axis, got_pd}, 3'b101);
      xfer({16'hA000, 16'h0000}, 32, rd);
      check(start_cnt == s0 + 2, "R7 strobe count", start_cnt - s0, 2);
      check(got_axis == 2'd1 && got_pd == 1'b0, "R7 fields", {got_axis, got_pd}, 3'b010);
      check(err_cnt == 0, "R7 no error", err_cnt, 0);
      loc_chk(7'h00, "R7 no reg change");
    end

    // R8: malformed commands
    begin
      logic [15:0] rd;
      int s0, e0;
      s0 = start_cnt; e0 = err_cnt;
      xfer({16'h8085, 16'h7777}, 32, rd);
      check(err_cnt == e0 + 1, "R8 both bytes", err_cnt - e0, 1);
      loc_chk(7'h05, "R8 no write");
      xfer({16'h4000, 16'h0000}, 32, rd);
      check(err_cnt == e0 + 2, "R8 select clear", err_cnt - e0, 2);
      check(start_cnt == s0, "R8 no strobe", start_cnt - s0, 0);
    end

    // R3 / R5 / R9: sweep of writes and readbacks
    for (int k = 0; k < 6; k++) spi_write(7'(k * 21 + 3), 16'(16'h1357 * (k + 1)), 32);
    for (int k = 0; k < 6; k++) spi_read_chk(7'(k * 21 + 3), "R5 sweep");
    for (int k = 0; k < 6; k++) loc_chk(7'(k * 21 + 3), "R3 sweep");
    loc_chk(7'h05, "R9 final"); loc_chk(7'h45, "R9 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule